// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level translation structure held in memory. A translate request carries the linear address. On acceptance the walker also samples a directory base value taken from a control register. It then makes two dependent reads through a valid/ready memory read port: first a directory entry, then a page-table entry. The result is a one-cycle physical-address pulse, or a one-cycle page-fault pulse that carries the faulting linear address and the level at which a non-present entry stopped the walk.

The linear address is split into three fields. The top 10 bits index the directory. The next 10 bits index a page table. The low 12 bits are the byte offset within a 4096-byte page. Every entry is a 32-bit word: bits [31:12] give the base of the next structure, and bit 0 is the present flag. Only one walk is in flight at a time.

The walk is driven by a state machine with five states. IDLE accepts a request (transition IDLE→READ_DIR). READ_DIR issues the directory read and waits for its data; it goes to READ_TBL on a present entry and to FAULT otherwise. READ_TBL issues the table read; it goes to DONE on a present entry and to FAULT otherwise. DONE and FAULT each last one cycle and return to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_rd_valid, done_valid and fault_valid are all 0.
- R2: The first read of a walk is at address {dir_base[31:12], lin[31:22], 2'b00}. This is the directory base plus the directory index times 4, and it is always word aligned.
- R3: When the directory entry has bit 0 set, the second read is at address {pde[31:12], lin[21:12], 2'b00}. This is the table base plus the table index times 4.
- R4: When the table entry has bit 0 set, done_valid pulses and done_phys_addr = {pte[31:12], lin[11:0]}.
- R5: A directory entry with bit 0 clear ends the walk with fault_valid = 1 and fault_level = 0 (0 means the directory level). fault_lin_addr equals the requested linear address, and no table read is issued.
- R6: A table entry with bit 0 clear ends the walk with fault_valid = 1 and fault_level = 1 (1 means the table level), with fault_lin_addr set to the requested address.
- R7: A read request keeps mem_rd_valid high and mem_rd_addr stable until mem_rd_ready is seen. After acceptance it is dropped, so that each level makes exactly one read.
- R8: req_ready is 1 only in IDLE. Requests presented during a walk are ignored, and req_ready returns in the cycle after the result pulse.
- R9: dir_base is sampled only when a request is accepted, and its bits [11:0] are ignored. A change during a walk does not alter the read addresses.
- R10: Entry bits [11:1] do not affect addresses or results.
- R11: done_valid and fault_valid are never high together, and each is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_lin_addr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Directory base from the control register |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| done_valid | output | 1 | Translation complete pulse |
| done_phys_addr | output | 32 | Physical address |
| fault_valid | output | 1 | Page fault pulse |
| fault_lin_addr | output | 32 | Linear address that faulted |
| fault_level | output | 1 | 0 directory level, 1 table level |

## Verification
The test sweeps every directory index once. This separates the present and non-present directory paths and exercises the directory address arithmetic over the whole index field. A second sweep holds the directory index fixed and runs every table index and many offsets, which separates table-level faults from completed translations and shows that the offset passes through untouched. Across both sweeps the memory stalls its ready signal for a varying number of cycles and varies its response delay. The directory base carries non-zero low bits, and every entry carries non-zero bits [11:1]. On some walks the requester holds a different address and directory base on the request port while the walk runs. Each of these would change the observed read addresses if sampling, masking or ignoring were wrong.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_READ_DIR = 3'd1,
        S_READ_TBL = 3'd2,
        S_DONE     = 3'd3,
        S_FAULT    = 3'd4
    } walk_state_t;

    typedef enum logic {
        LVL_DIR = 1'b0,
        LVL_TBL = 1'b1
    } walk_level_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int FRAME_W     = 20,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [FRAME_W-1:0] base_frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  addr
);
    localparam int OFF_W = ADDR_W - FRAME_W;

    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] idx_scaled;

    always_comb begin
        base_full  = {base_frame, {OFF_W{1'b0}}};
        idx_scaled = ADDR_W'(idx) << ENTRY_SHIFT;
        addr       = base_full + idx_scaled;
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ADDR_W      = 32,
    parameter int FRAME_W     = 20,
    parameter int PRESENT_BIT = 0
) (
    input  logic [ADDR_W-1:0]  entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    localparam int OFF_W = ADDR_W - FRAME_W;

    logic unused_attr_bits;

    always_comb begin
        present          = entry[PRESENT_BIT];
        frame            = entry[ADDR_W-1:OFF_W];
        unused_attr_bits = ^entry[OFF_W-1:0];
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int DIR_IDX_W  = 10,
    parameter int TBL_IDX_W  = 10,
    parameter int PAGE_OFF_W = 12,
    localparam int ADDR_W    = DIR_IDX_W + TBL_IDX_W + PAGE_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin_addr,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_phys_addr,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_lin_addr,
    output logic              fault_level
);
    localparam int FRAME_W     = ADDR_W - PAGE_OFF_W;
    localparam int ENTRY_SHIFT = 2;

    walk_state_t       state_q, state_d;
    logic [ADDR_W-1:0] lin_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [FRAME_W-1:0] page_frame_q;
    logic              issued_q;
    walk_level_t       lvl_q;

    logic              ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic [ADDR_W-1:0] dir_entry_addr;
    logic [ADDR_W-1:0] tbl_entry_addr;
    logic              rd_fire;
    logic              rsp_take;
    logic              unused_base_low;

    assign unused_base_low = ^dir_base[PAGE_OFF_W-1:0];

    ptw_entry_decode #(
        .ADDR_W      (ADDR_W),
        .FRAME_W     (FRAME_W),
        .PRESENT_BIT (0)
    ) u_decode (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    ptw_entry_addr #(
        .ADDR_W      (ADDR_W),
        .FRAME_W     (FRAME_W),
        .IDX_W       (DIR_IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_dir_addr (
        .base_frame (dir_frame_q),
        .idx        (lin_q[ADDR_W-1 -: DIR_IDX_W]),
        .addr       (dir_entry_addr)
    );

    ptw_entry_addr #(
        .ADDR_W      (ADDR_W),
        .FRAME_W     (FRAME_W),
        .IDX_W       (TBL_IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_tbl_addr (
        .base_frame (tbl_frame_q),
        .idx        (lin_q[PAGE_OFF_W +: TBL_IDX_W]),
        .addr       (tbl_entry_addr)
    );

    assign rd_fire  = mem_rd_valid && mem_rd_ready;
    assign rsp_take = issued_q && mem_rsp_valid;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = S_READ_DIR;
            end
            S_READ_DIR: begin
                if (rsp_take) state_d = ent_present ? S_READ_TBL : S_FAULT;
            end
            S_READ_TBL: begin
                if (rsp_take) state_d = ent_present ? S_DONE : S_FAULT;
            end
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            lin_q        <= '0;
            dir_frame_q  <= '0;
            tbl_frame_q  <= '0;
            page_frame_q <= '0;
            issued_q     <= 1'b0;
            lvl_q        <= LVL_DIR;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        lin_q       <= req_lin_addr;
                        dir_frame_q <= dir_base[ADDR_W-1:PAGE_OFF_W];
                        issued_q    <= 1'b0;
                    end
                end
                S_READ_DIR: begin
                    if (rd_fire) issued_q <= 1'b1;
                    if (rsp_take) begin
                        issued_q    <= 1'b0;
                        tbl_frame_q <= ent_frame;
                        lvl_q       <= LVL_DIR;
                    end
                end
                S_READ_TBL: begin
                    if (rd_fire) issued_q <= 1'b1;
                    if (rsp_take) begin
                        issued_q     <= 1'b0;
                        page_frame_q <= ent_frame;
                        lvl_q        <= LVL_TBL;
                    end
                end
                default: begin
                    issued_q <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        mem_rd_valid   = 1'b0;
        mem_rd_addr    = dir_entry_addr;
        done_valid     = 1'b0;
        fault_valid    = 1'b0;
        done_phys_addr = {page_frame_q, lin_q[PAGE_OFF_W-1:0]};
        fault_lin_addr = lin_q;
        fault_level    = lvl_q;
        unique case (state_q)
            S_IDLE:     req_ready = 1'b1;
            S_READ_DIR: begin
                mem_rd_valid = !issued_q;
                mem_rd_addr  = dir_entry_addr;
            end
            S_READ_TBL: begin
                mem_rd_valid = !issued_q;
                mem_rd_addr  = tbl_entry_addr;
            end
            S_DONE:     done_valid  = 1'b1;
            S_FAULT:    fault_valid = 1'b1;
            default:    req_ready   = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_lin_addr,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              done_valid,
    input logic [ADDR_W-1:0] done_phys_addr,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_lin_addr
);
    logic [ADDR_W-1:0] lin_seen;
    logic              unused_phys_high;

    assign unused_phys_high = ^done_phys_addr[ADDR_W-1:OFF_W];

    always_ff @(posedge clk) begin
        if (!rst_n) lin_seen <= '0;
        else if (req_valid && req_ready) lin_seen <= req_lin_addr;
    end

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R11
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid); // R11
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R7
    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00)); // R2
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid); // R8
    AST_READY_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> req_ready); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_phys_addr[OFF_W-1:0] == lin_seen[OFF_W-1:0])); // R4
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_lin_addr == lin_seen)); // R5
endmodule

bind ptw_walker ptw_walker_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (PAGE_OFF_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_lin_addr   (req_lin_addr),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_ready   (mem_rd_ready),
    .mem_rd_addr    (mem_rd_addr),
    .done_valid     (done_valid),
    .done_phys_addr (done_phys_addr),
    .fault_valid    (fault_valid),
    .fault_lin_addr (fault_lin_addr)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin_addr = '0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_phys_addr;
    logic        fault_valid;
    logic [31:0] fault_lin_addr;
    logic        fault_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_lin_addr   (req_lin_addr),
        .dir_base       (dir_base),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_ready   (mem_rd_ready),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .done_valid     (done_valid),
        .done_phys_addr (done_phys_addr),
        .fault_valid    (fault_valid),
        .fault_lin_addr (fault_lin_addr),
        .fault_level    (fault_level)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory image: directory entries, with junk in bits [11:1] (R10)
    function automatic logic [31:0] pde_word(input logic [31:0] a);
        int unsigned i;
        i = int'(a[11:2]);
        return {20'(i * 37 + 5), 11'(i * 3 + 1), ((i % 7) != 3)};
    endfunction

    function automatic logic [31:0] pte_word(input logic [31:0] a);
        int unsigned k;
        k = int'(a[21:2]);
        return {20'(k * 13 + 291), 11'(k) ^ 11'h555, ((k % 5) != 4)};
    endfunction

    task automatic serve(input logic [31:0] exp_addr, input int stall, input int dly,
                         input logic [31:0] word, input string tag);
        int n;
        n = 0;
        while (mem_rd_valid !== 1'b1 && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(mem_rd_valid === 1'b1 && mem_rd_addr === exp_addr, tag, mem_rd_addr, exp_addr);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(mem_rd_valid === 1'b1 && mem_rd_addr === exp_addr, "R7 hold", mem_rd_addr, exp_addr);
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        chk(mem_rd_valid === 1'b0, "R7 single issue", {31'd0, mem_rd_valid}, 32'd0);
        for (int w = 0; w < dly; w++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = word;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    endtask

    task automatic translate(input logic [31:0] lin, input logic [31:0] base,
                             input bit busy, input int stall, input int dly);
        logic [31:0] daddr, pde, taddr, pte, phys;
        daddr = {base[31:12], lin[31:22], 2'b00};
        pde   = pde_word(daddr);
        taddr = {pde[31:12], lin[21:12], 2'b00};
        pte   = pte_word(taddr);
        phys  = {pte[31:12], lin[11:0]};

        @(negedge clk);
        chk(req_ready === 1'b1, "R8 idle ready", {31'd0, req_ready}, 32'd1);
        req_valid    = 1'b1;
        req_lin_addr = lin;
        dir_base     = base;
        @(negedge clk);
        if (busy) begin
            req_lin_addr = ~lin;
            dir_base     = ~base;
            chk(req_ready === 1'b0, "R8 busy", {31'd0, req_ready}, 32'd0);
        end else begin
            req_valid = 1'b0;
        end

        serve(daddr, stall, dly, pde, "R2 R9 dir read");
        if (!pde[0]) begin
            chk(fault_valid === 1'b1 && fault_level === 1'b0 && done_valid === 1'b0 && mem_rd_valid === 1'b0,
                "R5 dir fault", {28'd0, fault_valid, fault_level, done_valid, mem_rd_valid}, 32'h8);
            chk(fault_lin_addr === lin, "R5 fault addr", fault_lin_addr, lin);
        end else begin
            serve(taddr, stall, dly, pte, "R3 R10 tbl read");
            if (!pte[0]) begin
                chk(fault_valid === 1'b1 && fault_level === 1'b1 && done_valid === 1'b0,
                    "R6 tbl fault", {29'd0, fault_valid, fault_level, done_valid}, 32'h6);
                chk(fault_lin_addr === lin, "R6 fault addr", fault_lin_addr, lin);
            end else begin
                chk(done_valid === 1'b1 && fault_valid === 1'b0, "R4 done",
                    {30'd0, done_valid, fault_valid}, 32'h2);
                chk(done_phys_addr === phys, "R4 R10 phys", done_phys_addr, phys);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(done_valid === 1'b0 && fault_valid === 1'b0 && req_ready === 1'b1,
            "R11 R8 pulse end", {29'd0, done_valid, fault_valid, req_ready}, 32'h1);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && done_valid === 1'b0 && fault_valid === 1'b0,
            "R1 reset", {28'd0, req_ready, mem_rd_valid, done_valid, fault_valid}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_rd_valid === 1'b0, "R1 after reset",
            {30'd0, req_ready, mem_rd_valid}, 32'h2);

        // Sweep every directory index
        for (int d = 0; d < 1024; d++) begin
            translate({10'(d), 10'((d * 7) % 1024), 12'(d * 5)},
                      32'h0040_0000 | 32'(d & 12'hFFF),
                      (d % 4) == 0, d % 3, d % 2);
        end
        // Sweep every table index under one present directory entry
        for (int t = 0; t < 1024; t++) begin
            translate({10'd1, 10'(t), 12'(4095 - t)},
                      32'h00AB_C000 | 32'(t & 12'hFFF),
                      (t % 3) == 0, t % 4, t % 3);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule